// File: doc/BRIEF.md
# Endpoint Packet-Buffer Status Tracker

This block keeps, for each of eight USB device endpoints, a record of which packet slots in that endpoint's buffer hold a complete packet. Endpoint 0 has one slot. Every other endpoint has a first slot A and a second slot B. Slot B is used only when the endpoint is configured for ping-pong (dual-packet) buffering. The block takes per-endpoint event strobes from the USB engine (packet received from the host, packet delivered to the host) and from the processor side (packet read out, packet written in), plus a start-of-frame strobe. From these it maintains the slot bits that software reads through two 8-bit read-only status words.

A receive endpoint fills its slots when packets arrive from the host and empties them when the processor reads them. A transmit endpoint fills its slots when the processor writes them and empties them when the host has collected them. A receive endpoint interrupts when a slot fills. A transmit endpoint interrupts when a slot drains. An isochronous endpoint in dual mode does not track occupancy. Its A/B pair instead names the slot the processor may use in the current frame, and that pair swaps at every start of frame. Interrupts leave the block as one-cycle pulses, gated by a per-endpoint enable.

Configuration (direction, buffering mode, isochronous type) is expected to change only while reset is asserted.

Top module: `ep_buf_status`

## Requirements
- R1: Slot bits form a 16-bit view {stat_hi, stat_lo}. Endpoint e has slot A at bit 2e and slot B at bit 2e+1. Endpoint 0 has no slot B, so stat_lo bit 1 always reads 0.
- R2: After reset, stat_lo, stat_hi and irq are all 0, and every endpoint's USB-side and processor-side slot pointers select slot A.
- R3: On a receive endpoint (cfg_is_tx bit = 0), ev_host_rx sets the addressed slot bit. It also raises irq for that endpoint. Both are visible in the cycle after the strobe.
- R4: On a receive endpoint, ev_cpu_rd clears the addressed slot bit and raises no interrupt.
- R5: On a transmit endpoint (cfg_is_tx bit = 1), ev_cpu_wr sets the addressed slot bit and raises no interrupt.
- R6: On a transmit endpoint, ev_host_tx clears the addressed slot bit and raises irq for that endpoint in the cycle after the strobe.
- R7: With cfg_dual bit = 0, or on endpoint 0, only slot A is used and slot B reads 0. With cfg_dual bit = 1, the USB side and the processor side each address slots in the order A, B, A, B through their own pointers. A pointer advances only when its event takes effect.
- R8: If a clear and a set reach the same slot in one cycle, the clear is applied first and then the set. The bit ends at 1, and only the set's interrupt is produced. That means an interrupt on a receive endpoint and none on a transmit endpoint.
- R9: An endpoint with cfg_iso = 1 and cfg_dual = 1 (not endpoint 0) ignores all four event strobes. Its A/B pair goes from 00 to A=1 on the first sof, then swaps between A and B on each later sof, and it raises no interrupt.
- R10: irq is a registered one-cycle pulse per endpoint. A pulse is delivered only if the irq_en bit was 1 in the cycle of the causing event.
- R11: An event whose addressed slot is already in the target state is ignored, and so is an event of the wrong direction: ev_cpu_wr or ev_host_tx on a receive endpoint, or ev_host_rx or ev_cpu_rd on a transmit endpoint. An ignored event changes no bit, moves no pointer and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_is_tx | input | 8 | Per endpoint: 1 = transmit, 0 = receive |
| cfg_dual | input | 8 | Per endpoint: 1 = dual-packet buffering (ignored for endpoint 0) |
| cfg_iso | input | 8 | Per endpoint: 1 = isochronous (effective only with dual) |
| irq_en | input | 8 | Per-endpoint interrupt enable |
| ev_host_rx | input | 8 | Packet fully received from the host |
| ev_host_tx | input | 8 | Packet delivered to the host |
| ev_cpu_rd | input | 8 | Processor finished reading one packet |
| ev_cpu_wr | input | 8 | Processor finished writing one packet |
| sof | input | 1 | Start-of-frame strobe |
| stat_lo | output | 8 | Slot bits of endpoints 0 to 3 |
| stat_hi | output | 8 | Slot bits of endpoints 4 to 7 |
| irq | output | 8 | Per-endpoint interrupt pulses |

## Verification
The two functions that can meet in one cycle are the draining of a slot by one side and its refilling by the other side. This can happen on both receive and transmit endpoints, in single and in dual mode. Directed steps provoke the collision on a full single-slot receive endpoint and on a full single-slot transmit endpoint. They check that the bit stays at 1, and that the interrupt appears only on the receive endpoint. A long random sweep over eight configurations drives all four strobes at once with heavy overlap. It compares every cycle against an arithmetic model that applies the clear before the set, so collisions in dual mode, where pointers decide whether the two events meet, are judged as well.

// File: rtl/ep_stat_pkg.sv
package ep_stat_pkg;

    localparam int EP_COUNT = 8;

    typedef struct packed {
        logic is_tx;
        logic dual;
        logic iso;
    } ep_cfg_t;

    typedef struct packed {
        logic host_rx;
        logic host_tx;
        logic cpu_rd;
        logic cpu_wr;
    } ep_evt_t;

    typedef struct packed {
        logic [1:0] full;     // [0] slot A, [1] slot B
        logic       usb_ptr;  // 0 = A, 1 = B
        logic       cpu_ptr;
    } ep_state_t;

    localparam logic PTR_A = 1'b0;

    // frame indicator step for isochronous endpoints
    function automatic logic [1:0] iso_advance(input logic [1:0] cur);
        return (cur == 2'b00) ? 2'b01 : {cur[0], cur[1]};
    endfunction

endpackage

// File: rtl/ep_slot_tracker.sv
module ep_slot_tracker
    import ep_stat_pkg::*;
#(
    parameter bit HAS_B = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  ep_cfg_t    cfg,
    input  ep_evt_t    evt,
    input  logic       sof,
    output logic [1:0] slots,
    output logic       irq_raw
);

    ep_state_t st_q, st_d;
    logic dual_on, iso_on;
    logic set_req, clr_req, set_ptr, clr_ptr;
    logic set_ok, clr_ok, usb_ok, cpu_ok;
    logic [1:0] mid;

    assign dual_on = HAS_B && cfg.dual;
    assign iso_on  = dual_on && cfg.iso;

    always_comb begin
        set_req = cfg.is_tx ? evt.cpu_wr  : evt.host_rx;
        clr_req = cfg.is_tx ? evt.host_tx : evt.cpu_rd;
        set_ptr = dual_on ? (cfg.is_tx ? st_q.cpu_ptr : st_q.usb_ptr) : PTR_A;
        clr_ptr = dual_on ? (cfg.is_tx ? st_q.usb_ptr : st_q.cpu_ptr) : PTR_A;

        // completing side drains first, then the filling side
        mid    = st_q.full;
        clr_ok = 1'b0;
        set_ok = 1'b0;
        if (!iso_on && clr_req && st_q.full[clr_ptr]) begin
            clr_ok       = 1'b1;
            mid[clr_ptr] = 1'b0;
        end
        st_d.full = mid;
        if (!iso_on && set_req && !mid[set_ptr]) begin
            set_ok             = 1'b1;
            st_d.full[set_ptr] = 1'b1;
        end
        if (iso_on && sof) begin
            st_d.full = iso_advance(st_q.full);
        end
        if (!dual_on) begin
            st_d.full[1] = 1'b0;
        end

        usb_ok = cfg.is_tx ? clr_ok : set_ok;
        cpu_ok = cfg.is_tx ? set_ok : clr_ok;
        st_d.usb_ptr = dual_on ? (st_q.usb_ptr ^ usb_ok) : PTR_A;
        st_d.cpu_ptr = dual_on ? (st_q.cpu_ptr ^ cpu_ok) : PTR_A;

        if (cfg.is_tx) begin
            irq_raw = clr_ok && !(set_ok && (set_ptr == clr_ptr));
        end else begin
            irq_raw = set_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{full: 2'b00, usb_ptr: PTR_A, cpu_ptr: PTR_A};
        end else begin
            st_q <= st_d;
        end
    end

    assign slots = st_q.full;

endmodule

// File: rtl/ep_irq_stage.sv
module ep_irq_stage #(
    parameter int NUM_EP = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EP-1:0] raw,
    input  logic [NUM_EP-1:0] en,
    output logic [NUM_EP-1:0] pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= '0;
        end else begin
            pulse <= raw & en;
        end
    end

endmodule

// File: rtl/ep_buf_status.sv
module ep_buf_status
    import ep_stat_pkg::*;
#(
    parameter int NUM_EP = EP_COUNT,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EP-1:0] cfg_is_tx,
    input  logic [NUM_EP-1:0] cfg_dual,
    input  logic [NUM_EP-1:0] cfg_iso,
    input  logic [NUM_EP-1:0] irq_en,
    input  logic [NUM_EP-1:0] ev_host_rx,
    input  logic [NUM_EP-1:0] ev_host_tx,
    input  logic [NUM_EP-1:0] ev_cpu_rd,
    input  logic [NUM_EP-1:0] ev_cpu_wr,
    input  logic              sof,
    output logic [REG_W-1:0]  stat_lo,
    output logic [REG_W-1:0]  stat_hi,
    output logic [NUM_EP-1:0] irq
);

    localparam int FLAT_W = 2 * NUM_EP;

    logic [FLAT_W-1:0] slot_flat;
    logic [NUM_EP-1:0] irq_raw;

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        ep_cfg_t ecfg;
        ep_evt_t eevt;
        assign ecfg = '{is_tx: cfg_is_tx[e], dual: cfg_dual[e], iso: cfg_iso[e]};
        assign eevt = '{host_rx: ev_host_rx[e], host_tx: ev_host_tx[e],
                        cpu_rd: ev_cpu_rd[e], cpu_wr: ev_cpu_wr[e]};

        ep_slot_tracker #(
            .HAS_B (e != 0)
        ) u_trk (
            .clk     (clk),
            .rst     (rst),
            .cfg     (ecfg),
            .evt     (eevt),
            .sof     (sof),
            .slots   (slot_flat[2*e+1:2*e]),
            .irq_raw (irq_raw[e])
        );
    end

    ep_irq_stage #(
        .NUM_EP (NUM_EP)
    ) u_irq (
        .clk   (clk),
        .rst   (rst),
        .raw   (irq_raw),
        .en    (irq_en),
        .pulse (irq)
    );

    assign stat_lo = slot_flat[REG_W-1:0];
    assign stat_hi = slot_flat[2*REG_W-1:REG_W];

endmodule

// File: rtl/ep_buf_status_chk.sv
module ep_buf_status_chk #(
    parameter int NUM_EP = 8,
    parameter int REG_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_EP-1:0] cfg_dual,
    input logic [NUM_EP-1:0] cfg_iso,
    input logic [NUM_EP-1:0] irq_en,
    input logic [NUM_EP-1:0] ev_host_rx,
    input logic [NUM_EP-1:0] ev_host_tx,
    input logic [NUM_EP-1:0] ev_cpu_rd,
    input logic [NUM_EP-1:0] ev_cpu_wr,
    input logic              sof,
    input logic [REG_W-1:0]  stat_lo,
    input logic [REG_W-1:0]  stat_hi,
    input logic [NUM_EP-1:0] irq
);

    logic [2*REG_W-1:0] flat;
    assign flat = {stat_hi, stat_lo};

    assert_ep0_b_zero_R1: assert property (@(posedge clk) disable iff (rst)
        stat_lo[1] == 1'b0);

    for (genvar e = 0; e < NUM_EP; e++) begin : g_chk
        assert_irq_source_R6: assert property (@(posedge clk) disable iff (rst)
            irq[e] |-> $past(ev_host_rx[e] || ev_host_tx[e]));

        assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
            !$past(irq_en[e]) |-> !irq[e]);

        assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
            (!ev_host_rx[e] && !ev_host_tx[e] && !ev_cpu_rd[e] && !ev_cpu_wr[e] && !sof)
            |=> $stable(flat[2*e+1:2*e]));

        if (e != 0) begin : g_b
            assert_single_b_zero_R7: assert property (@(posedge clk) disable iff (rst)
                !$past(cfg_dual[e]) |-> !flat[2*e+1]);

            assert_iso_onehot_R9: assert property (@(posedge clk) disable iff (rst)
                $past(cfg_dual[e] && cfg_iso[e]) |-> $onehot0(flat[2*e+1:2*e]));
        end
    end

endmodule

bind ep_buf_status ep_buf_status_chk #(.NUM_EP(NUM_EP), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_dual(cfg_dual), .cfg_iso(cfg_iso), .irq_en(irq_en),
    .ev_host_rx(ev_host_rx), .ev_host_tx(ev_host_tx), .ev_cpu_rd(ev_cpu_rd),
    .ev_cpu_wr(ev_cpu_wr), .sof(sof), .stat_lo(stat_lo), .stat_hi(stat_hi), .irq(irq)
);

// File: tb/ep_buf_status_tb.sv
module ep_buf_status_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_is_tx = '0, cfg_dual = '0, cfg_iso = '0, irq_en = '0;
    logic [7:0] ev_host_rx = '0, ev_host_tx = '0, ev_cpu_rd = '0, ev_cpu_wr = '0;
    logic       sof = 1'b0;
    logic [7:0] stat_lo, stat_hi, irq;

    int checks = 0;
    int errors = 0;

    // arithmetic model state
    logic [1:0] m_full [8];
    logic       m_up   [8];
    logic       m_cp   [8];
    logic [7:0] m_irq;

    always #5 clk = ~clk;

    ep_buf_status u_dut (
        .clk(clk), .rst(rst), .cfg_is_tx(cfg_is_tx), .cfg_dual(cfg_dual),
        .cfg_iso(cfg_iso), .irq_en(irq_en), .ev_host_rx(ev_host_rx),
        .ev_host_tx(ev_host_tx), .ev_cpu_rd(ev_cpu_rd), .ev_cpu_wr(ev_cpu_wr),
        .sof(sof), .stat_lo(stat_lo), .stat_hi(stat_hi), .irq(irq)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        finish_run();
    end

    task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int e = 0; e < 8; e++) begin
            m_full[e] = 2'b00; m_up[e] = 1'b0; m_cp[e] = 1'b0;
        end
        m_irq = '0;
    endtask

    // one clock of the model, from the inputs currently driven
    task automatic model_clock();
        for (int e = 0; e < 8; e++) begin
            bit dual, iso, tx, sreq, creq, sp, cp, sok, cok, raw;
            dual = (e != 0) && cfg_dual[e];
            iso  = dual && cfg_iso[e];
            tx   = cfg_is_tx[e];
            raw  = 0;
            if (iso) begin
                if (sof) m_full[e] = (m_full[e] == 2'b00) ? 2'b01 : {m_full[e][0], m_full[e][1]};
            end else begin
                sreq = tx ? ev_cpu_wr[e] : ev_host_rx[e];
                creq = tx ? ev_host_tx[e] : ev_cpu_rd[e];
                sp   = dual ? (tx ? m_cp[e] : m_up[e]) : 0;
                cp   = dual ? (tx ? m_up[e] : m_cp[e]) : 0;
                cok  = creq && m_full[e][cp];
                if (cok) m_full[e][cp] = 1'b0;
                sok  = sreq && !m_full[e][sp];
                if (sok) m_full[e][sp] = 1'b1;
                if (dual) begin
                    if (tx) begin m_up[e] ^= cok; m_cp[e] ^= sok; end
                    else    begin m_up[e] ^= sok; m_cp[e] ^= cok; end
                end
                raw = tx ? (cok && !(sok && sp == cp)) : sok;
            end
            m_irq[e] = raw && irq_en[e];
        end
    endtask

    function automatic logic [15:0] model_flat();
        logic [15:0] f;
        for (int e = 0; e < 8; e++) f[2*e +: 2] = m_full[e];
        return f;
    endfunction

    task automatic clear_events();
        ev_host_rx = '0; ev_host_tx = '0; ev_cpu_rd = '0; ev_cpu_wr = '0; sof = 1'b0;
    endtask

    // inputs already driven at a falling edge; advance one cycle
    task automatic step();
        model_clock();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic dstep(input string tag, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] iq);
        step();
        check8({tag, " stat_lo"}, stat_lo, lo);
        check8({tag, " stat_hi"}, stat_hi, hi);
        check8({tag, " irq"}, irq, iq);
        clear_events();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clear_events();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        @(negedge clk);
        // ---------- directed ----------
        cfg_is_tx = 8'b0010_0100;  // ep2, ep5 transmit
        cfg_dual  = 8'b0100_0110;  // ep1, ep2, ep6 dual
        cfg_iso   = 8'b0100_0000;  // ep6 isochronous
        irq_en    = 8'hF7;         // ep3 masked
        do_reset();
        check8("R2 reset stat_lo", stat_lo, 8'h00);
        check8("R2 reset stat_hi", stat_hi, 8'h00);
        check8("R2 reset irq", irq, 8'h00);

        ev_host_rx[0] = 1; dstep("R1 R3 ep0 fill", 8'h01, 8'h00, 8'h01);
        dstep("R10 one-cycle pulse", 8'h01, 8'h00, 8'h00);
        ev_cpu_wr[0] = 1; ev_host_tx[0] = 1; dstep("R11 wrong direction", 8'h01, 8'h00, 8'h00);
        ev_host_rx[0] = 1; dstep("R11 already full", 8'h01, 8'h00, 8'h00);
        ev_cpu_rd[0] = 1; dstep("R4 ep0 read", 8'h00, 8'h00, 8'h00);
        ev_host_rx[1] = 1; dstep("R3 ep1 fill A", 8'h04, 8'h00, 8'h02);
        ev_host_rx[1] = 1; dstep("R7 ep1 fill B", 8'h0C, 8'h00, 8'h02);
        ev_host_rx[1] = 1; dstep("R11 R7 ep1 both full", 8'h0C, 8'h00, 8'h00);
        ev_cpu_rd[1] = 1; dstep("R7 ep1 read A", 8'h08, 8'h00, 8'h00);
        ev_host_rx[1] = 1; dstep("R7 ep1 refill A", 8'h0C, 8'h00, 8'h02);
        ev_cpu_wr[2] = 1; dstep("R5 ep2 write A", 8'h1C, 8'h00, 8'h00);
        ev_cpu_wr[2] = 1; dstep("R7 ep2 write B", 8'h3C, 8'h00, 8'h00);
        ev_host_tx[2] = 1; dstep("R6 ep2 send A", 8'h2C, 8'h00, 8'h04);
        ev_host_rx[3] = 1; dstep("R10 ep3 masked", 8'h6C, 8'h00, 8'h00);
        ev_cpu_wr[5] = 1; dstep("R5 ep5 write", 8'h6C, 8'h04, 8'h00);
        ev_cpu_wr[5] = 1; ev_host_tx[5] = 1; dstep("R8 tx collision", 8'h6C, 8'h04, 8'h00);
        ev_host_rx[4] = 1; dstep("R3 ep4 fill", 8'h6C, 8'h05, 8'h10);
        ev_host_rx[4] = 1; ev_cpu_rd[4] = 1; dstep("R8 rx collision", 8'h6C, 8'h05, 8'h10);
        sof = 1; dstep("R9 first frame", 8'h6C, 8'h15, 8'h00);
        sof = 1; ev_host_rx[6] = 1; ev_cpu_rd[6] = 1; dstep("R9 swap, events ignored", 8'h6C, 8'h25, 8'h00);
        ev_host_tx[5] = 1; dstep("R6 ep5 send", 8'h6C, 8'h21, 8'h20);

        // ---------- sweep over eight configurations ----------
        void'($urandom(32'h1234_5678));
        for (int p = 0; p < 8; p++) begin
            cfg_is_tx = p[0] ? 8'h5A : 8'hA5;
            cfg_dual  = p[1] ? 8'hF0 : 8'h0F;
            cfg_iso   = p[2] ? 8'hC3 : 8'h24;
            irq_en    = (p == 5) ? 8'h96 : 8'hFF;
            do_reset();
            check8("R2 sweep reset lo", stat_lo, 8'h00);
            check8("R2 sweep reset hi", stat_hi, 8'h00);
            for (int c = 0; c < 500; c++) begin
                logic [15:0] exp_flat;
                ev_host_rx = 8'($urandom & $urandom);
                ev_host_tx = 8'($urandom & $urandom);
                ev_cpu_rd  = 8'($urandom & $urandom);
                ev_cpu_wr  = 8'($urandom & $urandom);
                sof        = (($urandom % 5) == 0);
                step();
                exp_flat = model_flat();
                check8("R1 R3 R4 R5 R7 R8 R9 R11 sweep stat_lo", stat_lo, exp_flat[7:0]);
                check8("R1 R3 R4 R5 R7 R8 R9 R11 sweep stat_hi", stat_hi, exp_flat[15:8]);
                check8("R3 R6 R8 R10 sweep irq", irq, m_irq);
            end
            clear_events();
        end
        finish_run();
    end

endmodule